// File: doc/BRIEF.md
# Tag-Renaming Reorder Unit

This block sits between instruction decode and the issue queue of an out-of-order core. Each cycle it can accept one decoded instruction. The instruction carries an optional destination register and two source registers. The block places the instruction in the next free slot of an eight-entry circular reorder buffer, and the index of that slot becomes the instruction's tag. The tag is also recorded as the newest writer of the destination register. A branch, or any other instruction without a result, still takes a slot in order.

Each source operand leaves the block in the same cycle, in one of two forms:
- a ready value, taken from the architectural register file, from a finished but unretired entry, or from a completion arriving in that same cycle;
- a pending tag, which the consumer waits on.

A completion port writes results into their entries, possibly out of order. A retire side moves the oldest finished entry into the architectural registers, one per cycle, in program order. A flush input discards every in-flight entry and all rename mappings.

Top module: `rob_rename`

## Requirements
- R1: After reset the buffer is empty: `ren_ready` is 1, `ren_tag` is 0, `commit_valid` is 0, and all 32 architectural registers (indices 0 to 31) read as zero.
- R2: Each accepted instruction receives the tag shown on `ren_tag` in its acceptance cycle. Tags advance by one per accepted instruction, modulo 8, and the value holds while nothing is accepted.
- R3: A source register whose newest in-flight writer has not finished is returned with `srcN_ready` = 0 and `srcN_tag` equal to that writer's tag.
- R4: A source register with no in-flight writer is returned ready, with its architectural register value.
- R5: A source whose newest writer has finished but not retired is returned ready, with the finished value.
- R6: A completion whose tag matches a pending source in the same cycle makes that source ready with the completion value. A source is never reported pending on the tag being completed in that cycle.
- R7: Retirement happens only at the oldest entry, and only once it has finished. A younger entry that finishes first waits. After each retirement `commit_tag` advances by one.
- R8: A retiring entry with a destination writes its value to the architectural register. That register's mapping is released only if the retiring tag is still its newest writer. Otherwise later sources stay pending on the newer tag.
- R9: An instruction without a destination takes a tag and a slot in order, and it retires with `commit_has_dest` = 0.
- R10: When 8 entries are in flight, `ren_ready` is 0 and a presented instruction is ignored, so `ren_tag` does not change.
- R11: During a flush cycle nothing retires. Afterwards the buffer is empty (`ren_tag` = 0, `ren_ready` = 1) and every source reads the architectural value, which the flush does not alter.
- R12: A source that names the same register as its own instruction's destination sees the mapping from before this instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all in-flight entries and mappings |
| ren_valid | input | 1 | A decoded instruction is presented |
| ren_ready | output | 1 | Buffer has a free slot |
| ren_has_dest | input | 1 | Instruction writes a register |
| ren_dest | input | 5 | Destination register index |
| ren_src0 | input | 5 | First source register index |
| ren_src1 | input | 5 | Second source register index |
| ren_tag | output | 3 | Tag given to the presented instruction |
| src0_ready | output | 1 | First source value is available |
| src0_tag | output | 3 | Producer tag of first source when pending |
| src0_value | output | 32 | First source value when ready |
| src1_ready | output | 1 | Second source value is available |
| src1_tag | output | 3 | Producer tag of second source when pending |
| src1_value | output | 32 | Second source value when ready |
| cpl_valid | input | 1 | A result finishes this cycle |
| cpl_tag | input | 3 | Tag of the finishing entry |
| cpl_value | input | 32 | Result value |
| commit_valid | output | 1 | Oldest entry retires this cycle |
| commit_tag | output | 3 | Tag of the oldest entry |
| commit_has_dest | output | 1 | Retiring entry writes a register |
| commit_reg | output | 5 | Register written on retirement |
| commit_value | output | 32 | Value written on retirement |

## Verification
Sources are exercised in every state a producer can be in:
- no writer at all;
- a writer still pending;
- a writer finished but unretired;
- a writer finishing in the very same cycle;
- a writer already retired.

Each state produces a different ready flag and value, so any mixed-up forwarding path shows up. Completions are issued out of program order, which separates true in-order retirement from retire-on-finish.

Two patterns target the mapping and the buffer edges:
- A register is renamed twice before its older writer retires, which tells a guarded mapping release from an unconditional one.
- The buffer is filled to eight entries and then flushed while its head has just finished. This checks the stall, the ignored request, and that a flush neither retires nor alters the register file.

// File: rtl/rob_rename_pkg.sv
package rob_rename_pkg;

    parameter int unsigned NUM_ARCH  = 32;
    parameter int unsigned ROB_DEPTH = 8;
    parameter int unsigned XLEN      = 32;
    parameter int unsigned NSRC      = 2;

    localparam int unsigned REG_W = $clog2(NUM_ARCH);
    localparam int unsigned TAG_W = $clog2(ROB_DEPTH);
    localparam int unsigned CNT_W = TAG_W + 1;

    typedef logic [REG_W-1:0] areg_t;
    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [XLEN-1:0]  word_t;
    typedef logic [CNT_W-1:0] cnt_t;

    // one reorder slot
    typedef struct packed {
        logic  busy;
        logic  done;
        logic  wr;
        areg_t dst;
        word_t val;
    } rob_entry_t;

    // rename map entry: newest in-flight writer of a register
    typedef struct packed {
        logic live;
        tag_t tag;
    } map_entry_t;

    // resolved source operand
    typedef struct packed {
        logic  ready;
        tag_t  tag;
        word_t val;
    } operand_t;

    function automatic tag_t tag_inc(input tag_t t);
        tag_t r;
        if (t == tag_t'(ROB_DEPTH - 1))
            r = '0;
        else
            r = t + tag_t'(1);
        return r;
    endfunction

endpackage

// File: rtl/rob_rename_maptable.sv
module rob_rename_maptable
    import rob_rename_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       set_en,
    input  areg_t      set_reg,
    input  tag_t       set_tag,
    input  logic       clr_en,
    input  areg_t      clr_reg,
    input  tag_t       clr_tag,
    input  areg_t      rd_reg [NSRC],
    output map_entry_t rd_map [NSRC]
);

    map_entry_t tbl [NUM_ARCH];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < NUM_ARCH; i++) begin
                tbl[i].live <= 1'b0;
                tbl[i].tag  <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_ARCH; i++) begin
                if (set_en && set_reg == areg_t'(i)) begin
                    // a new writer always wins over a release
                    tbl[i].live <= 1'b1;
                    tbl[i].tag  <= set_tag;
                end else if (clr_en && clr_reg == areg_t'(i) &&
                             tbl[i].live && tbl[i].tag == clr_tag) begin
                    tbl[i].live <= 1'b0;
                end
            end
        end
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_rd
        assign rd_map[s] = tbl[rd_reg[s]];
    end

endmodule

// File: rtl/rob_rename_buffer.sv
module rob_rename_buffer
    import rob_rename_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  alloc_en,
    input  logic  alloc_wr,
    input  areg_t alloc_dst,
    input  logic  cpl_en,
    input  tag_t  cpl_tag,
    input  word_t cpl_val,
    output tag_t  tail_o,
    output tag_t  head_o,
    output logic  full_o,
    output logic  retire_o,
    output logic  head_wr_o,
    output areg_t head_dst_o,
    output word_t head_val_o,
    input  tag_t  rd_tag  [NSRC],
    output logic  rd_done [NSRC],
    output word_t rd_val  [NSRC]
);

    rob_entry_t ents [ROB_DEPTH];
    tag_t       head, tail;
    cnt_t       count;
    logic       retire;

    assign retire = ents[head].busy && ents[head].done && !flush;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
            for (int i = 0; i < ROB_DEPTH; i++) begin
                ents[i].busy <= 1'b0;
                ents[i].done <= 1'b0;
                ents[i].wr   <= 1'b0;
                ents[i].dst  <= '0;
                ents[i].val  <= '0;
            end
        end else begin
            if (alloc_en) begin
                ents[tail].busy <= 1'b1;
                ents[tail].done <= 1'b0;
                ents[tail].wr   <= alloc_wr;
                ents[tail].dst  <= alloc_dst;
                ents[tail].val  <= '0;
                tail            <= tag_inc(tail);
            end
            if (cpl_en && ents[cpl_tag].busy) begin
                ents[cpl_tag].done <= 1'b1;
                ents[cpl_tag].val  <= cpl_val;
            end
            if (retire) begin
                ents[head].busy <= 1'b0;
                ents[head].done <= 1'b0;
                head            <= tag_inc(head);
            end
            count <= count + cnt_t'(alloc_en) - cnt_t'(retire);
        end
    end

    assign tail_o     = tail;
    assign head_o     = head;
    assign full_o     = (count == cnt_t'(ROB_DEPTH));
    assign retire_o   = retire;
    assign head_wr_o  = ents[head].wr;
    assign head_dst_o = ents[head].dst;
    assign head_val_o = ents[head].val;

    for (genvar s = 0; s < NSRC; s++) begin : g_rd
        assign rd_done[s] = ents[rd_tag[s]].busy && ents[rd_tag[s]].done;
        assign rd_val[s]  = ents[rd_tag[s]].val;
    end

endmodule

// File: rtl/rob_rename_arf.sv
module rob_rename_arf
    import rob_rename_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  areg_t wr_reg,
    input  word_t wr_val,
    input  areg_t rd_reg [NSRC],
    output word_t rd_val [NSRC]
);

    word_t regs [NUM_ARCH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ARCH; i++)
                regs[i] <= '0;
        end else if (wr_en) begin
            regs[wr_reg] <= wr_val;
        end
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_rd
        assign rd_val[s] = regs[rd_reg[s]];
    end

endmodule

// File: rtl/rob_rename_operand.sv
module rob_rename_operand
    import rob_rename_pkg::*;
(
    input  map_entry_t map_i,
    input  logic       ent_done_i,
    input  word_t      ent_val_i,
    input  word_t      arf_val_i,
    input  logic       cpl_valid_i,
    input  tag_t       cpl_tag_i,
    input  word_t      cpl_val_i,
    output operand_t   opnd_o
);

    always_comb begin
        opnd_o.tag = map_i.tag;
        if (!map_i.live) begin
            opnd_o.ready = 1'b1;
            opnd_o.val   = arf_val_i;
        end else if (ent_done_i) begin
            opnd_o.ready = 1'b1;
            opnd_o.val   = ent_val_i;
        end else if (cpl_valid_i && cpl_tag_i == map_i.tag) begin
            opnd_o.ready = 1'b1;
            opnd_o.val   = cpl_val_i;
        end else begin
            opnd_o.ready = 1'b0;
            opnd_o.val   = '0;
        end
    end

endmodule

// File: rtl/rob_rename.sv
module rob_rename
    import rob_rename_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              ren_valid,
    output logic              ren_ready,
    input  logic              ren_has_dest,
    input  logic [REG_W-1:0]  ren_dest,
    input  logic [REG_W-1:0]  ren_src0,
    input  logic [REG_W-1:0]  ren_src1,
    output logic [TAG_W-1:0]  ren_tag,
    output logic              src0_ready,
    output logic [TAG_W-1:0]  src0_tag,
    output logic [XLEN-1:0]   src0_value,
    output logic              src1_ready,
    output logic [TAG_W-1:0]  src1_tag,
    output logic [XLEN-1:0]   src1_value,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag,
    input  logic [XLEN-1:0]   cpl_value,
    output logic              commit_valid,
    output logic [TAG_W-1:0]  commit_tag,
    output logic              commit_has_dest,
    output logic [REG_W-1:0]  commit_reg,
    output logic [XLEN-1:0]   commit_value
);

    areg_t      src_reg  [NSRC];
    map_entry_t src_map  [NSRC];
    tag_t       src_ptag [NSRC];
    logic       ent_done [NSRC];
    word_t      ent_val  [NSRC];
    word_t      arf_val  [NSRC];
    operand_t   opnd     [NSRC];

    tag_t  tail, head;
    logic  full, retire, head_wr;
    areg_t head_dst;
    word_t head_val;
    logic  alloc;

    assign src_reg[0] = ren_src0;
    assign src_reg[1] = ren_src1;

    assign alloc = ren_valid && !full && !flush;

    rob_rename_maptable u_map (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .set_en  (alloc && ren_has_dest),
        .set_reg (ren_dest),
        .set_tag (tail),
        .clr_en  (retire && head_wr),
        .clr_reg (head_dst),
        .clr_tag (head),
        .rd_reg  (src_reg),
        .rd_map  (src_map)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_ptag
        assign src_ptag[s] = src_map[s].tag;
    end

    rob_rename_buffer u_rob (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .alloc_en   (alloc),
        .alloc_wr   (ren_has_dest),
        .alloc_dst  (ren_dest),
        .cpl_en     (cpl_valid),
        .cpl_tag    (cpl_tag),
        .cpl_val    (cpl_value),
        .tail_o     (tail),
        .head_o     (head),
        .full_o     (full),
        .retire_o   (retire),
        .head_wr_o  (head_wr),
        .head_dst_o (head_dst),
        .head_val_o (head_val),
        .rd_tag     (src_ptag),
        .rd_done    (ent_done),
        .rd_val     (ent_val)
    );

    rob_rename_arf u_arf (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (retire && head_wr),
        .wr_reg (head_dst),
        .wr_val (head_val),
        .rd_reg (src_reg),
        .rd_val (arf_val)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_opnd
        rob_rename_operand u_opnd (
            .map_i       (src_map[s]),
            .ent_done_i  (ent_done[s]),
            .ent_val_i   (ent_val[s]),
            .arf_val_i   (arf_val[s]),
            .cpl_valid_i (cpl_valid),
            .cpl_tag_i   (cpl_tag),
            .cpl_val_i   (cpl_value),
            .opnd_o      (opnd[s])
        );
    end

    assign ren_ready       = !full;
    assign ren_tag         = tail;
    assign src0_ready      = opnd[0].ready;
    assign src0_tag        = opnd[0].tag;
    assign src0_value      = opnd[0].val;
    assign src1_ready      = opnd[1].ready;
    assign src1_tag        = opnd[1].tag;
    assign src1_value      = opnd[1].val;
    assign commit_valid    = retire;
    assign commit_tag      = head;
    assign commit_has_dest = head_wr;
    assign commit_reg      = head_dst;
    assign commit_value    = head_val;

endmodule

// File: rtl/rob_rename_checker.sv
module rob_rename_checker
    import rob_rename_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             flush,
    input logic             ren_valid,
    input logic             ren_ready,
    input logic [TAG_W-1:0] ren_tag,
    input logic             src0_ready,
    input logic [TAG_W-1:0] src0_tag,
    input logic             src1_ready,
    input logic [TAG_W-1:0] src1_tag,
    input logic             cpl_valid,
    input logic [TAG_W-1:0] cpl_tag,
    input logic             commit_valid,
    input logic [TAG_W-1:0] commit_tag
);

    // R2: accepted instruction moves the tag on by one
    a_r2_tag_advance: assert property (@(posedge clk) disable iff (rst)
        (ren_valid && ren_ready && !flush) |=> ren_tag == tag_inc($past(ren_tag)));

    // R2: no acceptance keeps the tag
    a_r2_tag_hold: assert property (@(posedge clk) disable iff (rst)
        (!ren_valid && !flush) |=> $stable(ren_tag));

    // R10: full buffer ignores a presented instruction
    a_r10_full_ignores: assert property (@(posedge clk) disable iff (rst)
        (!ren_ready && !flush) |=> $stable(ren_tag));

    // R6: no pending source on a tag completing now
    a_r6_wakeup_src0: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && !src0_ready) |-> (cpl_tag != src0_tag));
    a_r6_wakeup_src1: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && !src1_ready) |-> (cpl_tag != src1_tag));

    // R7: retirement walks the buffer in order
    a_r7_head_advance: assert property (@(posedge clk) disable iff (rst)
        commit_valid |=> commit_tag == tag_inc($past(commit_tag)));

    // R11: flush retires nothing and empties the buffer
    a_r11_no_commit: assert property (@(posedge clk) disable iff (rst)
        flush |-> !commit_valid);
    a_r11_empty_after: assert property (@(posedge clk) disable iff (rst)
        flush |=> (ren_ready && ren_tag == '0 && !commit_valid));

endmodule

bind rob_rename rob_rename_checker u_chk (.*);

// File: tb/rob_rename_bench.sv
module rob_rename_bench;
    import rob_rename_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        ren_valid = 1'b0;
    logic        ren_ready;
    logic        ren_has_dest = 1'b0;
    logic [4:0]  ren_dest = '0;
    logic [4:0]  ren_src0 = '0;
    logic [4:0]  ren_src1 = '0;
    logic [2:0]  ren_tag;
    logic        src0_ready, src1_ready;
    logic [2:0]  src0_tag, src1_tag;
    logic [31:0] src0_value, src1_value;
    logic        cpl_valid = 1'b0;
    logic [2:0]  cpl_tag = '0;
    logic [31:0] cpl_value = '0;
    logic        commit_valid;
    logic [2:0]  commit_tag;
    logic        commit_has_dest;
    logic [4:0]  commit_reg;
    logic [31:0] commit_value;

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        bit          wr;
        logic [4:0]  rg;
        logic [31:0] v;
    } exp_t;
    exp_t expq [$];

    always #2.5 clk = ~clk;

    rob_rename u_rob_rename (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        ren_valid = 1'b0;
        cpl_valid = 1'b0;
        flush     = 1'b0;
    endtask

    task automatic ren(input bit wr, input int d, input int s0, input int s1,
                       input logic [31:0] future_val);
        exp_t e;
        ren_valid    = 1'b1;
        ren_has_dest = wr;
        ren_dest     = 5'(d);
        ren_src0     = 5'(s0);
        ren_src1     = 5'(s1);
        e.wr = wr; e.rg = 5'(d); e.v = future_val;
        expq.push_back(e);
    endtask

    task automatic cpl(input int t, input logic [31:0] v);
        cpl_valid = 1'b1;
        cpl_tag   = 3'(t);
        cpl_value = v;
    endtask

    // monitor: compare every retirement with the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && commit_valid) begin
                if (expq.size() == 0) begin
                    chk("R7", "unexpected retirement", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk("R9", "commit_has_dest", 32'(commit_has_dest), 32'(e.wr));
                    if (e.wr) begin
                        chk("R8", "commit_reg", 32'(commit_reg), 32'(e.rg));
                        chk("R8", "commit_value", commit_value, e.v);
                    end
                end
            end
        end
    end

    initial begin
        #1000000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        cyc(); ren_src0 = 5'd5; #1;
        chk("R1", "ren_ready", 32'(ren_ready), 32'd1);
        chk("R1", "ren_tag", 32'(ren_tag), 32'd0);
        chk("R1", "commit_valid", 32'(commit_valid), 32'd0);
        chk("R1", "arf reg5", src0_value, 32'd0);
        chk("R4", "src0_ready idle", 32'(src0_ready), 32'd1);

        // I0: reg1 <- f(reg2, reg3)
        cyc(); ren(1, 1, 2, 3, 32'h11); #1;
        chk("R4", "src0_ready", 32'(src0_ready), 32'd1);
        chk("R4", "src1_value", src1_value, 32'd0);
        chk("R2", "tag I0", 32'(ren_tag), 32'd0);

        // I1: reg2 <- f(reg1, reg1)
        cyc(); ren(1, 2, 1, 1, 32'h22); #1;
        chk("R3", "src0_ready", 32'(src0_ready), 32'd0);
        chk("R3", "src0_tag", 32'(src0_tag), 32'd0);
        chk("R2", "tag I1", 32'(ren_tag), 32'd1);

        // I2: branch on reg2
        cyc(); ren(0, 0, 2, 4, 32'h0); #1;
        chk("R3", "branch src pending", 32'(src0_ready), 32'd0);
        chk("R3", "branch src tag", 32'(src0_tag), 32'd1);
        chk("R9", "branch tag", 32'(ren_tag), 32'd2);

        // younger I1 finishes first
        cyc(); cpl(1, 32'h22); #1;
        chk("R7", "no commit before anything done", 32'(commit_valid), 32'd0);

        // I3: reg3 <- f(reg2, reg1) while I0 completes now
        cyc(); ren(1, 3, 2, 1, 32'h33); cpl(0, 32'h11); #1;
        chk("R5", "forward finished value", src0_value, 32'h22);
        chk("R5", "forward ready", 32'(src0_ready), 32'd1);
        chk("R6", "same-cycle wakeup ready", 32'(src1_ready), 32'd1);
        chk("R6", "same-cycle wakeup value", src1_value, 32'h11);
        chk("R7", "younger done head not", 32'(commit_valid), 32'd0);
        chk("R2", "tag I3", 32'(ren_tag), 32'd3);

        // I4: reg3 <- f(reg3, reg1): reads the old reg3 writer
        cyc(); ren(1, 3, 3, 1, 32'h44); #1;
        chk("R12", "own dest src pending", 32'(src0_ready), 32'd0);
        chk("R12", "own dest src prior tag", 32'(src0_tag), 32'd3);
        chk("R5", "finished head forwarded", src1_value, 32'h11);
        chk("R7", "head retires", 32'(commit_valid), 32'd1);

        cyc(); cpl(2, 32'h0);
        cyc(); cpl(3, 32'h33); #1;
        chk("R9", "branch retires no dest", 32'(commit_has_dest), 32'd0);
        cyc(); #1;
        chk("R8", "I3 retires", 32'(commit_tag), 32'd3);

        // reg3 still mapped to I4, reg1 released to the register file
        cyc(); ren(0, 0, 3, 1, 32'h0); #1;
        chk("R8", "stale release kept", 32'(src0_ready), 32'd0);
        chk("R8", "newer tag kept", 32'(src0_tag), 32'd4);
        chk("R8", "released reg reads arf", src1_value, 32'h11);
        chk("R2", "tag I5", 32'(ren_tag), 32'd5);

        cyc(); ren(0, 0, 2, 0, 32'h0); #1;
        chk("R8", "arf reg2", src0_value, 32'h22);

        // fill remaining slots
        for (int k = 0; k < 5; k++) begin
            cyc(); ren(0, 0, 0, 0, 32'h0);
        end

        cyc(); ren_valid = 1'b1; ren_has_dest = 1'b1; ren_dest = 5'd3;
        cpl(4, 32'h44); #1;
        chk("R10", "full not ready", 32'(ren_ready), 32'd0);
        chk("R10", "full tag", 32'(ren_tag), 32'd4);

        cyc(); flush = 1'b1; expq.delete(); #1;
        chk("R10", "ignored rename", 32'(ren_tag), 32'd4);
        chk("R11", "no commit in flush", 32'(commit_valid), 32'd0);

        cyc(); ren(1, 4, 3, 1, 32'h55); #1;
        chk("R11", "ready after flush", 32'(ren_ready), 32'd1);
        chk("R11", "tag after flush", 32'(ren_tag), 32'd0);
        chk("R11", "map cleared src ready", 32'(src0_ready), 32'd1);
        chk("R11", "arf kept reg3", src0_value, 32'h33);
        chk("R11", "arf kept reg1", src1_value, 32'h11);

        cyc(); cpl(0, 32'h55);
        cyc();
        cyc(); ren_src0 = 5'd4; #1;
        chk("R8", "retired value in arf", src0_value, 32'h55);
        chk("R8", "retired src ready", 32'(src0_ready), 32'd1);

        repeat (3) cyc();
        chk("R7", "all expected retirements seen", 32'(expq.size()), 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule